// File: doc/BRIEF.md
# I2C Target Controller with Host-Paced Byte Handshake

This block is the bus side of an I2C target (slave) that leaves every decision to host logic. It watches the two open-drain lines, recognises START and STOP, shifts bytes in and out and drives SDA only while SCL is low. After every byte it raises an interrupt. It then holds SCL low until the host has serviced the event, so that the master's clock waits for the host.

The block does not compare addresses. The host reads the address/direction byte from the receive data port and decides whether it is addressed. It then writes a command that chooses ACK or NACK and, for a read, starts transmission of a byte it loaded beforehand. The same command-per-byte handshake governs every later data byte in both directions. A NACK, whether the host sends it or the master does, makes the block let go of the bus until the next START or STOP.

Top module: `i2c_hp_target`

## Requirements
- R1: After reset, scl_oe_o and sda_oe_o are 0 (both lines released), irq_o is 0 and status_o is all zero.
- R2: While en_i is 0, bus traffic produces no interrupt, no clock hold and no acknowledge. SDA reads high in the 9th clock.
- R3: After a START, the 8th rising SCL edge sets irq_o. It also sets status_o[0] (byte done) and status_o[1] (address phase), copies the last received bit into status_o[2] (direction, 1 = master reads), and presents the whole byte, first bit in the MSB, on rx_data_o.
- R4: From the SCL falling edge after a completed byte, scl_oe_o stays 1 until the host writes a command (host_we_i=1 with host_sel_i=1). That write clears irq_o and status_o[0].
- R5: A command with host_wdata_i[0]=1 (ACK) makes SDA read low during the 9th clock. The block releases SDA after that clock when no transmission follows.
- R6: A command with host_wdata_i[0]=0 (NACK) leaves SDA high in the 9th clock. Further bytes then cause no interrupt, no hold and no acknowledge until a START or STOP.
- R7: In receive, each data byte sets irq_o with status_o[1]=0, shows the byte on rx_data_o, and is acknowledged per the next command.
- R8: After an ACK command with host_wdata_i[1]=1 (TRANSMIT), the byte last written with host_sel_i=0 goes out MSB first, one bit per SCL clock, starting right after the 9th clock. SDA changes only while SCL is low.
- R9: In transmit, the master's acknowledge bit sets irq_o and is recorded in status_o[3] (1 = NACK). After a master ACK, SCL is held until a TRANSMIT command, which sends the newly loaded byte.
- R10: After a master NACK, SCL is not held, SDA stays released, and further clocks read all ones.
- R11: A STOP sets status_o[4]. A START clears it. A repeated START from any state restarts the address phase.
- R12: SCL is never held low while the block is pulling SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; 0 releases the bus and clears state |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock hold), 0 releases |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Write target: 0 transmit data, 1 command |
| host_wdata_i | input | 8 | Write data; command bit 0 = ACK, bit 1 = TRANSMIT |
| rx_data_o | output | 8 | Last completed received byte |
| status_o | output | 5 | {stop seen, master NACK, direction, address phase, byte done} |
| irq_o | output | 1 | Byte-complete interrupt |

## Verification
A wrong engine state shows at the ports within one SCL bit period. The ACK slot reads the wrong level, SCL is held when it should not be (or not held when it should), or a transmitted bit differs from the loaded byte. A lost or late byte-complete flag is visible at irq_o within a few system clocks of the 8th rising edge. The bench therefore samples the 9th-clock SDA level, the clock-hold output and the status fields at every byte boundary, in both directions and after each kind of NACK.

// File: rtl/i2c_hp_pkg.sv
package i2c_hp_pkg;

    localparam int BYTE_W      = 8;
    localparam int SYNC_STAGES = 2;

    // command bit positions in a host command write
    localparam int CMD_ACK_BIT = 0;
    localparam int CMD_TX_BIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_WAITLOW,
        ST_STALL,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        logic stop_seen;
        logic master_nack;
        logic dir;
        logic addr_phase;
        logic byte_done;
    } hp_status_t;

    // open-drain: pulling the line low encodes a 0
    function automatic logic pull_for(input logic bit_val);
        return ~bit_val;
    endfunction

endpackage

// File: rtl/i2c_hp_sync.sv
module i2c_hp_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = i2c_hp_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_hp_busmon.sv
module i2c_hp_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_hp_hostif.sv
module i2c_hp_hostif #(
    parameter int BYTE_W = i2c_hp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we_i,
    input  logic              host_sel_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] tx_data,
    output logic              cmd_we,
    output logic              cmd_ack,
    output logic              cmd_tx
);
    import i2c_hp_pkg::*;

    assign cmd_we = host_we_i & host_sel_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            cmd_ack <= 1'b0;
            cmd_tx  <= 1'b0;
        end else if (host_we_i) begin
            if (host_sel_i) begin
                cmd_ack <= host_wdata_i[CMD_ACK_BIT];
                cmd_tx  <= host_wdata_i[CMD_TX_BIT];
            end else begin
                tx_data <= host_wdata_i;
            end
        end
    end
endmodule

// File: rtl/i2c_hp_engine.sv
module i2c_hp_engine #(
    parameter int BYTE_W = i2c_hp_pkg::BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en_i,
    input  logic                   sda_s,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_det,
    input  logic                   stop_det,
    input  logic [BYTE_W-1:0]      tx_data,
    input  logic                   cmd_we,
    input  logic                   cmd_ack,
    input  logic                   cmd_tx,
    output logic                   scl_oe,
    output logic                   sda_oe,
    output logic [BYTE_W-1:0]      rx_data,
    output i2c_hp_pkg::hp_status_t status,
    output logic                   irq
);
    import i2c_hp_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              in_tx;
    logic              next_tx;
    hp_status_t        st;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rx_data <= '0;
            st      <= '0;
            sda_oe  <= 1'b0;
            in_tx   <= 1'b0;
            next_tx <= 1'b0;
        end else begin
            // a host command services the pending byte event
            if (cmd_we) st.byte_done <= 1'b0;

            if (start_det) begin
                state         <= ST_RX;
                cnt           <= '0;
                st.addr_phase <= 1'b1;
                st.stop_seen  <= 1'b0;
                sda_oe        <= 1'b0;
                in_tx         <= 1'b0;
            end else if (stop_det) begin
                state        <= ST_IDLE;
                st.stop_seen <= 1'b1;
                sda_oe       <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-3:0], sda_s};
                            if (cnt == LAST_BIT) begin
                                rx_data      <= {rx_sh, sda_s};
                                st.byte_done <= 1'b1;
                                if (st.addr_phase) st.dir <= sda_s;
                                state        <= ST_WAITLOW;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_WAITLOW: begin
                        if (scl_fall) state <= ST_STALL;
                    end
                    ST_STALL: begin
                        if (!st.byte_done) begin
                            if (in_tx) begin
                                if (cmd_tx) begin
                                    state  <= ST_TX;
                                    tx_sh  <= tx_data;
                                    sda_oe <= pull_for(tx_data[BYTE_W-1]);
                                    cnt    <= '0;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (cmd_ack) begin
                                sda_oe  <= 1'b1;
                                next_tx <= cmd_tx;
                                state   <= ST_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            st.addr_phase <= 1'b0;
                            cnt           <= '0;
                            if (next_tx) begin
                                state  <= ST_TX;
                                in_tx  <= 1'b1;
                                tx_sh  <= tx_data;
                                sda_oe <= pull_for(tx_data[BYTE_W-1]);
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXACK;
                            end else begin
                                cnt    <= cnt + 1'b1;
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= pull_for(tx_sh[BYTE_W-2]);
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            st.master_nack <= sda_s;
                            st.byte_done   <= 1'b1;
                        end else if (scl_fall) begin
                            state <= st.master_nack ? ST_IGNORE : ST_STALL;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe = (state == ST_STALL) && st.byte_done;
    assign status = st;
    assign irq    = st.byte_done;
endmodule

// File: rtl/i2c_hp_target.sv
module i2c_hp_target #(
    parameter int BYTE_W = i2c_hp_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              host_we_i,
    input  logic              host_sel_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic [4:0]        status_o,
    output logic              irq_o
);
    import i2c_hp_pkg::*;

    logic [1:0]        lines_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] tx_data;
    logic              cmd_we, cmd_ack, cmd_tx;
    hp_status_t        st;

    i2c_hp_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (lines_s)
    );

    i2c_hp_busmon u_mon (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_hp_hostif #(.BYTE_W(BYTE_W)) u_host (
        .clk          (clk),
        .rst          (rst),
        .host_we_i    (host_we_i),
        .host_sel_i   (host_sel_i),
        .host_wdata_i (host_wdata_i),
        .tx_data      (tx_data),
        .cmd_we       (cmd_we),
        .cmd_ack      (cmd_ack),
        .cmd_tx       (cmd_tx)
    );

    i2c_hp_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .sda_s     (lines_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_data   (tx_data),
        .cmd_we    (cmd_we),
        .cmd_ack   (cmd_ack),
        .cmd_tx    (cmd_tx),
        .scl_oe    (scl_oe_o),
        .sda_oe    (sda_oe_o),
        .rx_data   (rx_data_o),
        .status    (st),
        .irq       (irq_o)
    );

    assign status_o = st;
endmodule

// File: rtl/i2c_hp_checker.sv
module i2c_hp_checker (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic       scl_i,
    input logic       sda_i,
    input logic       scl_oe_o,
    input logic       sda_oe_o,
    input logic       host_we_i,
    input logic       host_sel_i,
    input logic [4:0] status_o,
    input logic       irq_o
);
    logic rst_q;

    // R1: one cycle after reset was high, everything is released and clear
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            a_r1_reset_quiet: assert (!scl_oe_o && !sda_oe_o && !irq_o && status_o == 5'd0)
                else $error("R1 reset state violated");
        end
    end

    // R2: disabled block leaves the bus alone and raises nothing
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!scl_oe_o && !sda_oe_o && !irq_o));

    // R4: the clock is held only while an event is pending for the host
    a_r4_hold_needs_event: assert property (@(posedge clk) disable iff (rst)
        scl_oe_o |-> irq_o);

    // R4: a command write retires the pending interrupt
    a_r4_cmd_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (host_we_i && host_sel_i && irq_o) |=> !irq_o);

    // R8: SDA starts being pulled only while SCL is low
    a_r8_sda_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_i);

    // R11: stop flag appears only with both lines high
    a_r11_stop_lines_high: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[4]) |-> (scl_i && sda_i));

    // R12: never hold SCL while pulling SDA
    a_r12_hold_sda_free: assert property (@(posedge clk) disable iff (rst)
        scl_oe_o |-> !sda_oe_o);
endmodule

bind i2c_hp_target i2c_hp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .host_we_i  (host_we_i),
    .host_sel_i (host_sel_i),
    .status_o   (status_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_hp_target_tb.sv
module i2c_hp_target_tb;

    localparam int QT = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       host_we = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       scl_oe, sda_oe, irq;
    logic [7:0] rx_data;
    logic [4:0] status;
    logic       scl_bus, sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    i2c_hp_target u_dut (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .scl_i        (scl_bus),
        .sda_i        (sda_bus),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .host_we_i    (host_we),
        .host_sel_i   (host_sel),
        .host_wdata_i (host_wdata),
        .rx_data_o    (rx_data),
        .status_o     (status),
        .irq_o        (irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; tick(QT);
        m_scl_low = 1'b0; wait_scl_high(); tick(QT);
        m_sda_low = 1'b1; tick(QT);
        m_scl_low = 1'b1; tick(QT);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick(QT);
        m_scl_low = 1'b0; wait_scl_high(); tick(QT);
        m_sda_low = 1'b0; tick(QT);
    endtask

    task automatic m_bit(input logic b);
        m_sda_low = !b; tick(QT);
        m_scl_low = 1'b0; wait_scl_high(); tick(2 * QT);
        m_scl_low = 1'b1; tick(QT);
    endtask

    task automatic m_read(output logic b);
        m_sda_low = 1'b0; tick(QT);
        m_scl_low = 1'b0; wait_scl_high(); tick(QT);
        b = sda_bus; tick(QT);
        m_scl_low = 1'b1; tick(QT);
    endtask

    task automatic m_send_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) m_bit(d[i]);
    endtask

    task automatic m_read_byte(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            m_read(b);
            d[i] = b;
        end
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(irq == 1'b0, "R1 irq clear", irq, 0);
        chk(status == 5'd0, "R1 status clear", status, 0);
    endtask

    task automatic t_disabled();
        logic a;
        en = 1'b0;
        m_start();
        m_send_byte(8'hB4);
        tick(8);
        chk(irq == 1'b0 && scl_oe == 1'b0, "R2 no irq or hold while disabled", {irq, scl_oe}, 0);
        m_read(a);
        chk(a == 1'b1, "R2 no acknowledge while disabled", a, 1);
        m_stop();
        chk(status == 5'd0, "R2 status untouched", status, 0);
    endtask

    task automatic t_write();
        logic a;
        en = 1'b1;
        tick(4);
        m_start();
        m_send_byte(8'hB4);
        tick(8);
        chk(irq == 1'b1, "R3 irq after address", irq, 1);
        chk(status[2:0] == 3'b011, "R3 done, addr phase, dir=0", status[2:0], 3'b011);
        chk(rx_data == 8'hB4, "R3 address byte", rx_data, 8'hB4);
        chk(scl_oe == 1'b1, "R4 clock held", scl_oe, 1);
        tick(50);
        chk(scl_bus == 1'b0, "R4 clock still held", scl_bus, 0);
        host_write(1'b1, 8'h01);
        tick(2);
        chk(irq == 1'b0 && status[0] == 1'b0, "R4 command clears irq", {irq, status[0]}, 0);
        m_read(a);
        chk(a == 1'b0, "R5 address acknowledged", a, 0);
        tick(8);
        chk(sda_oe == 1'b0, "R5 SDA released after ack", sda_oe, 0);
        m_send_byte(8'h3C);
        tick(8);
        chk(irq == 1'b1 && status[1] == 1'b0, "R7 data irq, addr phase clear", {irq, status[1]}, 2'b10);
        chk(rx_data == 8'h3C, "R7 data byte 1", rx_data, 8'h3C);
        host_write(1'b1, 8'h01);
        m_read(a);
        chk(a == 1'b0, "R7 data byte 1 acked", a, 0);
        m_send_byte(8'hC3);
        tick(8);
        chk(rx_data == 8'hC3 && irq == 1'b1, "R7 data byte 2", rx_data, 8'hC3);
        host_write(1'b1, 8'h00);
        m_read(a);
        chk(a == 1'b1, "R6 NACK leaves SDA high", a, 1);
        m_send_byte(8'h00);
        tick(8);
        chk(irq == 1'b0 && scl_oe == 1'b0, "R6 ignored byte: no irq, no hold", {irq, scl_oe}, 0);
        m_read(a);
        chk(a == 1'b1, "R6 ignored byte not acked", a, 1);
        m_stop();
        tick(8);
        chk(status[4] == 1'b1, "R11 stop flag set", status[4], 1);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        m_start();
        tick(8);
        chk(status[4] == 1'b0, "R11 START clears stop flag", status[4], 0);
        m_send_byte(8'hB5);
        tick(8);
        chk(status[2:0] == 3'b111, "R3 read direction", status[2:0], 3'b111);
        chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R12 hold with SDA free", {scl_oe, sda_oe}, 2'b10);
        host_write(1'b0, 8'hA5);
        host_write(1'b1, 8'h03);
        m_read(a);
        chk(a == 1'b0, "R5 read address acked", a, 0);
        m_read_byte(d);
        chk(d == 8'hA5, "R8 first byte MSB first", d, 8'hA5);
        m_bit(1'b0);
        tick(8);
        chk(irq == 1'b1 && status[3] == 1'b0, "R9 irq with master ACK", {irq, status[3]}, 2'b10);
        chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R9 hold after master ACK", {scl_oe, sda_oe}, 2'b10);
        host_write(1'b0, 8'h5C);
        host_write(1'b1, 8'h02);
        m_read_byte(d);
        chk(d == 8'h5C, "R9 second byte sent", d, 8'h5C);
        m_bit(1'b1);
        tick(8);
        chk(irq == 1'b1 && status[3] == 1'b1, "R9 master NACK recorded", {irq, status[3]}, 2'b11);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 no hold after master NACK", {scl_oe, sda_oe}, 0);
        host_write(1'b1, 8'h00);
        m_read_byte(d);
        chk(d == 8'hFF, "R10 bus released", d, 8'hFF);
        m_start();
        m_send_byte(8'hB4);
        tick(8);
        chk(irq == 1'b1 && status[1] == 1'b1 && rx_data == 8'hB4,
            "R11 repeated START restarts address phase", rx_data, 8'hB4);
        host_write(1'b1, 8'h00);
        m_read(a);
        chk(a == 1'b1, "R6 address NACK", a, 1);
        m_stop();
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_disabled();
        t_write();
        t_read();
        tick(10);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule